// File: doc/BRIEF.md
# DDR3 Command and Address Formatter

This block sits between a memory controller's scheduler and the command pins of a single DDR3 rank. Each clock it can take one request: open a row, read, write, close one bank, close every bank, load a mode register, refresh, or do nothing. It turns that request into registered chip-select, row-strobe, column-strobe, write-enable, bank-address and address-pin values. A flat byte address is cut into row, bank and column fields, and the cut depends on whether the rank is built from 4-bit, 8-bit or 16-bit wide devices.

Several address pins do double duty. Bit 10 carries the auto-precharge flag on column commands and the all-banks choice on a precharge. Bit 12 carries the per-command burst length, and bit 11 carries the top column bit on 4-bit parts only. During a mode-register load, the bank pins name the register being written.

The block also keeps an open-row table for the eight banks. It reports combinationally, for the request currently presented, whether the addressed bank has a row open and whether that row is the one requested. The scheduler uses this to decide when an activate is needed.

Top module: `ddr3_cmd_fmt`

## Requirements
- R1: While `rst_n` is low, and after the first clock edge in reset, the bus shows deselect: cs_n, ras_n, cas_n and we_n are all 1, ba is 0, a is 0 and req_ready is 0. From the first edge after reset is released, req_ready is 1.
- R2: On a clock edge where no request is accepted (`req_valid` low, or `req_kind`=0 idle), the next bus value is deselect: all four strobes 1, ba 0, a 0.
- R3: `req_kind` takes these values: 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 mode load, 7 refresh. The strobes {cs_n,ras_n,cas_n,we_n} are driven as 0011 for activate, 0101 for read, 0100 for write, 0010 for both precharges, 0000 for mode load and 0001 for refresh.
- R4: `org_sel` selects the device width: 0 is x4, 1 is x8, and 2 or 3 is x16. The column takes the lowest bits of `req_addr`: 11 bits for x4 and 10 bits otherwise. The bank takes the next 3 bits, and the row takes the bits above the bank: 15 bits for x4 and x8, 14 bits for x16.
- R5: An activate drives ba with the bank and a with the row. For x16, a[14] is 0.
- R6: A read or write drives ba with the bank and a[9:0] with column bits 9..0. a[11] carries column bit 10 for x4 and is 0 otherwise. a[10] is `req_ap`. a[12] is `req_bl8`, where 1 means a full burst of 8 and 0 means a chopped burst of 4. The remaining pins are 0.
- R7: A single-bank precharge drives a[10]=0, ba with the bank, and all other address pins 0.
- R8: A precharge-all drives a[10]=1 and all other address pins 0.
- R9: A mode load drives a[14:0] with req_addr[14:0], ba[1:0] with req_addr[16:15], and ba[2] with 0.
- R10: The tracker works as follows:
  - `bank_open` is 1 when the addressed bank has a row open.
  - `row_hit` is 1 when that open row equals the requested row.
  - An activate opens a row in its bank.
  - A single-bank precharge closes only its bank.
  - A precharge-all closes every bank.
  - A read or write with `req_ap`=1 closes its bank.
- R11: Every bus output is registered. A request accepted at one clock edge appears on the pins right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_kind | input | 3 | Request type (see R3) |
| req_addr | input | 29 | Flat address, or mode-load opcode and register select |
| req_ap | input | 1 | Auto-precharge for read or write |
| req_bl8 | input | 1 | 1 = burst of 8, 0 = chop to 4 |
| org_sel | input | 2 | Device width select |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address pins |
| a | output | 15 | Address pins |
| bank_open | output | 1 | Addressed bank has an open row |
| row_hit | output | 1 | Addressed row is the open one |

## Verification
The main test walks one request sequence through all three device widths. Column patterns 0x155, 0x2AA and 0x7FF expose a swapped or dropped column bit, a wrongly placed a[11], and flag bits leaking into column bits. Rows at the top of each width's range, 0x7FFF and 0x3FFF, separate the x8 and x16 row cuts. The sequence pairs same-row and other-row accesses and closes banks by three routes: single precharge, precharge-all and auto-precharge. This shows whether a close reaches only its own bank, and whether a hit compares the row as well as the open flag.

// File: rtl/ddr3_fmt_pkg.sv
// Package: request kinds, width selects and strobe patterns shared by
// the formatter and its sub-blocks. Assumes the standard DDR3 strobe set.
package ddr3_fmt_pkg;

    typedef enum logic [2:0] {
        K_IDLE = 3'd0,
        K_ACT  = 3'd1,
        K_RD   = 3'd2,
        K_WR   = 3'd3,
        K_PRE  = 3'd4,
        K_PREA = 3'd5,
        K_MRS  = 3'd6,
        K_REF  = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        ORG_X4  = 2'd0,
        ORG_X8  = 2'd1,
        ORG_X16 = 2'd2,
        ORG_X16B = 2'd3
    } org_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobes_t;

    localparam strobes_t STB_DESEL = 4'b1111;
    localparam strobes_t STB_ACT   = 4'b0011;
    localparam strobes_t STB_RD    = 4'b0101;
    localparam strobes_t STB_WR    = 4'b0100;
    localparam strobes_t STB_PRE   = 4'b0010;
    localparam strobes_t STB_MRS   = 4'b0000;
    localparam strobes_t STB_REF   = 4'b0001;

endpackage

// File: rtl/ddr3_addr_split.sv
// Cuts a flat address into row, bank and column by device width.
// Assumes layout {row, bank, column}, column widest on x4 (COL_W bits),
// one bit narrower on x8/x16, row one bit narrower on x16.
module ddr3_addr_split
    import ddr3_fmt_pkg::*;
#(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3,
    parameter int COL_W  = 11
) (
    input  logic [COL_W+BANK_W+ROW_W-1:0] addr,
    input  logic [1:0]                    org,
    output logic [ROW_W-1:0]              row,
    output logic [BANK_W-1:0]             bank,
    output logic [COL_W-1:0]              col
);
    localparam int NCOL_W = COL_W - 1;

    // Field select: wide-column cut for x4, narrow cut otherwise.
    always_comb begin
        if (org_e'(org) == ORG_X4) begin
            col  = addr[COL_W-1:0];
            bank = addr[COL_W +: BANK_W];
            row  = addr[COL_W+BANK_W +: ROW_W];
        end else begin
            col  = {1'b0, addr[NCOL_W-1:0]};
            bank = addr[NCOL_W +: BANK_W];
            row  = addr[NCOL_W+BANK_W +: ROW_W];
            if (org[1]) row[ROW_W-1] = 1'b0;
        end
    end
endmodule

// File: rtl/ddr3_row_tracker.sv
// Open-row table: one valid bit and row per bank. Activate sets, single
// close clears one bank, close-all clears every bank. Query is combinational
// and reflects state before the current edge's update.
module ddr3_row_tracker #(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_row,
    input  logic              close_one,
    input  logic              close_all,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    output logic              is_open,
    output logic              is_hit
);
    localparam int NUM_BANKS = 1 << BANK_W;

    logic [NUM_BANKS-1:0] vld_vec;
    logic [ROW_W-1:0]     row_tab [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             v_q;
        logic [ROW_W-1:0] r_q;
        logic             sel;
        assign sel = (bank == BANK_W'(b));

        // Per-bank state update on open and close events.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                r_q <= '0;
            end else if (set_row && sel) begin
                v_q <= 1'b1;
                r_q <= row;
            end else if (close_all || (close_one && sel)) begin
                v_q <= 1'b0;
            end
        end
        assign vld_vec[b] = v_q;
        assign row_tab[b] = r_q;
    end

    // Lookup of the addressed bank.
    always_comb begin
        is_open = vld_vec[bank];
        is_hit  = vld_vec[bank] && (row_tab[bank] == row);
    end
endmodule

// File: rtl/ddr3_cmd_encode.sv
// Builds the next strobe, bank and address pin values for one request.
// Assumes pin roles: a[COL_W-1] auto-precharge/all-banks, a[COL_W] top
// column bit on x4, a[COL_W+1] burst length select.
module ddr3_cmd_encode
    import ddr3_fmt_pkg::*;
#(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3,
    parameter int COL_W  = 11
) (
    input  logic                          fire,
    input  logic [2:0]                    kind,
    input  logic [1:0]                    org,
    input  logic [COL_W+BANK_W+ROW_W-1:0] raw,
    input  logic [ROW_W-1:0]              row,
    input  logic [BANK_W-1:0]             bank,
    input  logic [COL_W-1:0]              col,
    input  logic                          ap,
    input  logic                          bl8,
    output strobes_t                      stb,
    output logic [BANK_W-1:0]             ba_n,
    output logic [ROW_W-1:0]              a_n
);
    localparam int AP_BIT  = COL_W - 1;
    localparam int HI_BIT  = COL_W;
    localparam int BC_BIT  = COL_W + 1;
    localparam int LOW_COL = COL_W - 1;

    // Command decode to pin values; anything not accepted is deselect.
    always_comb begin
        stb  = STB_DESEL;
        ba_n = '0;
        a_n  = '0;
        if (fire) begin
            case (req_kind_e'(kind))
                K_ACT: begin
                    stb  = STB_ACT;
                    ba_n = bank;
                    a_n  = row;
                end
                K_RD, K_WR: begin
                    stb  = (req_kind_e'(kind) == K_RD) ? STB_RD : STB_WR;
                    ba_n = bank;
                    a_n[LOW_COL-1:0] = col[LOW_COL-1:0];
                    a_n[HI_BIT]  = (org_e'(org) == ORG_X4) ? col[COL_W-1] : 1'b0;
                    a_n[AP_BIT]  = ap;
                    a_n[BC_BIT]  = bl8;
                end
                K_PRE: begin
                    stb  = STB_PRE;
                    ba_n = bank;
                end
                K_PREA: begin
                    stb  = STB_PRE;
                    a_n[AP_BIT] = 1'b1;
                end
                K_MRS: begin
                    stb  = STB_MRS;
                    ba_n = BANK_W'(raw[ROW_W +: 2]);
                    a_n  = raw[ROW_W-1:0];
                end
                K_REF:   stb = STB_REF;
                default: stb = STB_DESEL;
            endcase
        end
    end
endmodule

// File: rtl/ddr3_cmd_fmt.sv
// Top: accepts one request per clock, splits its address, updates the
// open-row table and registers the command bus. Assumes a single rank and
// that timing between commands is enforced upstream.
module ddr3_cmd_fmt
    import ddr3_fmt_pkg::*;
#(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3,
    parameter int COL_W  = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [2:0]                    req_kind,
    input  logic [COL_W+BANK_W+ROW_W-1:0] req_addr,
    input  logic                          req_ap,
    input  logic                          req_bl8,
    input  logic [1:0]                    org_sel,
    output logic                          cs_n,
    output logic                          ras_n,
    output logic                          cas_n,
    output logic                          we_n,
    output logic [BANK_W-1:0]             ba,
    output logic [ROW_W-1:0]              a,
    output logic                          bank_open,
    output logic                          row_hit
);
    logic              fire;
    logic [ROW_W-1:0]  f_row;
    logic [BANK_W-1:0] f_bank;
    logic [COL_W-1:0]  f_col;
    strobes_t          stb_n;
    strobes_t          stb_q;
    logic [BANK_W-1:0] ba_n;
    logic [ROW_W-1:0]  a_n;
    logic              is_act, is_pre, is_prea, is_apcol;

    assign fire    = req_valid && req_ready;
    assign is_act  = fire && (req_kind_e'(req_kind) == K_ACT);
    assign is_pre  = fire && (req_kind_e'(req_kind) == K_PRE);
    assign is_prea = fire && (req_kind_e'(req_kind) == K_PREA);
    assign is_apcol = fire && req_ap &&
                      ((req_kind_e'(req_kind) == K_RD) || (req_kind_e'(req_kind) == K_WR));

    ddr3_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_split (
        .addr(req_addr), .org(org_sel), .row(f_row), .bank(f_bank), .col(f_col)
    );

    ddr3_row_tracker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .set_row(is_act), .close_one(is_pre || is_apcol), .close_all(is_prea),
        .bank(f_bank), .row(f_row),
        .is_open(bank_open), .is_hit(row_hit)
    );

    ddr3_cmd_encode #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_enc (
        .fire(fire), .kind(req_kind), .org(org_sel), .raw(req_addr),
        .row(f_row), .bank(f_bank), .col(f_col), .ap(req_ap), .bl8(req_bl8),
        .stb(stb_n), .ba_n(ba_n), .a_n(a_n)
    );

    // Ready rises one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) req_ready <= 1'b0;
        else        req_ready <= 1'b1;
    end

    // Command bus output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= STB_DESEL;
            ba    <= '0;
            a     <= '0;
        end else begin
            stb_q <= stb_n;
            ba    <= ba_n;
            a     <= a_n;
        end
    end

    assign cs_n  = stb_q.cs_n;
    assign ras_n = stb_q.ras_n;
    assign cas_n = stb_q.cas_n;
    assign we_n  = stb_q.we_n;
endmodule

// File: rtl/ddr3_cmd_fmt_chk.sv
// Checker for the formatter's port behaviour; bound to every instance.
module ddr3_cmd_fmt_chk #(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3,
    parameter int COL_W  = 11
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic [2:0]                    req_kind,
    input logic [COL_W+BANK_W+ROW_W-1:0] req_addr,
    input logic                          req_ap,
    input logic                          req_bl8,
    input logic                          cs_n,
    input logic                          ras_n,
    input logic                          cas_n,
    input logic                          we_n,
    input logic [BANK_W-1:0]             ba,
    input logic [ROW_W-1:0]              a,
    input logic                          bank_open,
    input logic                          row_hit
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r1_reset_desel: assert property (@(posedge clk)
        !rst_n |=> (cs_n && ras_n && cas_n && we_n && !req_ready));

    a_r2_no_accept_desel: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (cs_n && ras_n && cas_n && we_n));

    a_r3_act_code: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 3'd1) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0011));

    a_r6_col_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (req_kind == 3'd2 || req_kind == 3'd3))
        |=> (a[COL_W-1] == $past(req_ap) && a[COL_W+1] == $past(req_bl8)
             && ras_n && !cas_n));

    a_r7_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 3'd4) |=> (!a[COL_W-1] && {cs_n, ras_n, cas_n, we_n} == 4'b0010));

    a_r8_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 3'd5) |=> (a[COL_W-1] && {cs_n, ras_n, cas_n, we_n} == 4'b0010));

    a_r9_mode_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 3'd6) |=> (!ba[BANK_W-1] && ba[1:0] == $past(req_addr[ROW_W +: 2])));

    a_r10_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 3'd5) |=> !bank_open);

    a_r10_hit_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        row_hit |-> bank_open);
endmodule

bind ddr3_cmd_fmt ddr3_cmd_fmt_chk #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_ap(req_ap), .req_bl8(req_bl8),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a(a),
    .bank_open(bank_open), .row_hit(row_hit)
);

// File: tb/ddr3_cmd_fmt_bench.sv
module ddr3_cmd_fmt_bench;

    typedef struct packed {
        logic [2:0]  kind;
        logic [1:0]  org;
        logic [14:0] row;
        logic [2:0]  bank;
        logic [10:0] col;
        logic        ap;
        logic        bl8;
        logic [3:0]  cmd;
        logic [2:0]  eba;
        logic [14:0] ea;
        logic        eopen;
        logic        ehit;
    } vec_t;

    localparam int NV = 16;
    // kind org row bank col ap bl8 | cmd ba a open hit
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'd1, 15'h1234, 3'd2, 11'h000, 1'b0, 1'b0, 4'b0011, 3'd2, 15'h1234, 1'b0, 1'b0},
        '{3'd2, 2'd1, 15'h1234, 3'd2, 11'h155, 1'b0, 1'b1, 4'b0101, 3'd2, 15'h1155, 1'b1, 1'b1},
        '{3'd3, 2'd1, 15'h1234, 3'd2, 11'h2AA, 1'b0, 1'b0, 4'b0100, 3'd2, 15'h02AA, 1'b1, 1'b1},
        '{3'd2, 2'd1, 15'h0001, 3'd2, 11'h003, 1'b0, 1'b1, 4'b0101, 3'd2, 15'h1003, 1'b1, 1'b0},
        '{3'd1, 2'd1, 15'h7FFF, 3'd5, 11'h000, 1'b0, 1'b0, 4'b0011, 3'd5, 15'h7FFF, 1'b0, 1'b0},
        '{3'd4, 2'd1, 15'h0000, 3'd2, 11'h000, 1'b0, 1'b0, 4'b0010, 3'd2, 15'h0000, 1'b1, 1'b0},
        '{3'd1, 2'd0, 15'h0042, 3'd2, 11'h000, 1'b0, 1'b0, 4'b0011, 3'd2, 15'h0042, 1'b0, 1'b0},
        '{3'd3, 2'd0, 15'h0042, 3'd2, 11'h7FF, 1'b1, 1'b1, 4'b0100, 3'd2, 15'h1FFF, 1'b1, 1'b1},
        '{3'd2, 2'd0, 15'h0042, 3'd2, 11'h000, 1'b0, 1'b0, 4'b0101, 3'd2, 15'h0000, 1'b0, 1'b0},
        '{3'd1, 2'd2, 15'h3FFF, 3'd7, 11'h000, 1'b0, 1'b0, 4'b0011, 3'd7, 15'h3FFF, 1'b0, 1'b0},
        '{3'd2, 2'd2, 15'h3FFF, 3'd7, 11'h3FF, 1'b0, 1'b1, 4'b0101, 3'd7, 15'h13FF, 1'b1, 1'b1},
        '{3'd5, 2'd1, 15'h7FFF, 3'd5, 11'h000, 1'b0, 1'b0, 4'b0010, 3'd0, 15'h0400, 1'b1, 1'b1},
        '{3'd2, 2'd1, 15'h0000, 3'd7, 11'h000, 1'b0, 1'b1, 4'b0101, 3'd7, 15'h1000, 1'b0, 1'b0},
        '{3'd6, 2'd1, 15'h0009, 3'd6, 11'h0A5, 1'b0, 1'b0, 4'b0000, 3'd2, 15'h38A5, 1'b0, 1'b0},
        '{3'd7, 2'd1, 15'h0000, 3'd0, 11'h000, 1'b0, 1'b0, 4'b0001, 3'd0, 15'h0000, 1'b0, 1'b0},
        '{3'd0, 2'd1, 15'h0000, 3'd0, 11'h000, 1'b0, 1'b0, 4'b1111, 3'd0, 15'h0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [28:0] req_addr = '0;
    logic        req_ap = 1'b0;
    logic        req_bl8 = 1'b0;
    logic [1:0]  org_sel = 2'd1;
    logic        cs_n, ras_n, cas_n, we_n, bank_open, row_hit;
    logic [2:0]  ba;
    logic [14:0] a;
    int          n_tests = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    ddr3_cmd_fmt u_ddr3_cmd_fmt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_ap(req_ap), .req_bl8(req_bl8),
        .org_sel(org_sel), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a(a), .bank_open(bank_open), .row_hit(row_hit)
    );

    function automatic logic [28:0] mkaddr(logic [1:0] org, logic [14:0] row,
                                           logic [2:0] bank, logic [10:0] col);
        if (org == 2'd0) return (29'(row) << 14) | (29'(bank) << 11) | 29'(col);
        return (29'(row) << 13) | (29'(bank) << 10) | 29'(col[9:0]);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_bus(string tag, logic [3:0] cmd, logic [2:0] eb, logic [14:0] ea);
        check(tag, {13'd0, cs_n, ras_n, cas_n, we_n, ba, a}, {13'd0, cmd, eb, ea});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_bus("R1 reset bus", 4'b1111, 3'd0, 15'd0);
        check("R1 ready low in reset", {31'd0, req_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);

        // R4 R5 R6 R7 R8 R9 R10: vector walk across widths
        for (int i = 0; i < NV; i++) begin
            req_valid = 1'b1;
            req_kind  = VECS[i].kind;
            org_sel   = VECS[i].org;
            req_addr  = mkaddr(VECS[i].org, VECS[i].row, VECS[i].bank, VECS[i].col);
            req_ap    = VECS[i].ap;
            req_bl8   = VECS[i].bl8;
            #1;
            check($sformatf("R10 open vec%0d", i), {31'd0, bank_open}, {31'd0, VECS[i].eopen});
            check($sformatf("R10 hit vec%0d", i), {31'd0, row_hit}, {31'd0, VECS[i].ehit});
            @(negedge clk);
            check_bus($sformatf("R3 R4 bus vec%0d", i), VECS[i].cmd, VECS[i].eba, VECS[i].ea);
        end

        // R2: valid low masks a real command
        req_kind = 3'd1; req_addr = mkaddr(2'd1, 15'h0055, 3'd3, 11'd0); req_valid = 1'b0;
        @(negedge clk);
        check_bus("R2 valid low deselect", 4'b1111, 3'd0, 15'd0);
        check("R2 bank untouched", {31'd0, bank_open}, 32'd0);

        // R11: the command is not on the pins before the edge, only after it
        req_valid = 1'b1;
        #1;
        check_bus("R11 before edge", 4'b1111, 3'd0, 15'd0);
        @(negedge clk);
        check_bus("R11 after edge", 4'b0011, 3'd3, 15'h0055);
        req_valid = 1'b0;
        #1;
        check("R10 act opens bank3", {30'd0, bank_open, row_hit}, 32'd3);

        // R1: reset mid-run clears the bus and the tracker
        rst_n = 1'b0;
        @(negedge clk);
        check_bus("R1 reset again", 4'b1111, 3'd0, 15'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tracker cleared", {31'd0, bank_open}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule